// File: doc/BRIEF.md
# Serial Memory Access Permission Checker

This block sits beside the serial-bus controller of a protected EEPROM and decides, for the address currently being accessed, whether a read may proceed, whether a write may commit, and whether a write should be acknowledged but silently dropped. The storage holds eight 128-byte blocks, each split into eight 16-byte pages. Separately from it sit a 16-byte protection page and a 16-byte identification page, which are reached through a distinct device code (`cfgSel`). The controller turns the three outputs into ACK, NACK, or ACK-without-commit. It does not handle the bus protocol, the storage of protection fields or the memory array.

Permissions are layered. Each block has a two-bit code. Block 0 also has a write-enable bit for each page. Protection-page bytes 0 to 8 are guarded by sticky lock bits. A separate two-bit code guards the upper protection bytes and the whole identification page. Two fixed bytes accept writes but never change. The write-protect pin overrides every write path.

The checker keeps the last loaded target address, so that a read that follows an address-setting write is judged against the same target. A newly loaded address is also passed straight through in the cycle it arrives, so the controller can decide inside the same acknowledge slot.

Top module: `blk_perm_check`

## Requirements
- R1: For a memory target (`cfgSel`=0), `readAllow` equals bit 1 of the target block's code. The code for block b sits at `blockCodes[2b+1:2b]`, and the block is `wordAddr[9:7]`.
- R2: For blocks 1 to 7, `writeAllow` is 1 exactly when the block code is 11b and `wpPin` is 0. `silentIgnore` is 0.
- R3: For block 0, `writeAllow` is 1 only when the block 0 code is 11b, `page0WrEn[p]` is 1 for page p = `wordAddr[6:4]`, and `wpPin` is 0.
- R4: In config space, protection bytes 0 to 8 (`wordAddr[7:0]` below 9) are always readable. With `wpPin` low, `writeAllow` equals `stickyBits[k]` for byte k, and `silentIgnore` equals its inverse.
- R5: Protection bytes 9 to 13 and identification bytes 0x10 to 0x1F have `readAllow` = `apCode[1]`. `writeAllow` is 1 exactly when `apCode` is 11b and `wpPin` is 0.
- R6: Protection bytes 14 and 15 have `readAllow` = `apCode[1]` and never `writeAllow`. `silentIgnore` is 1 when `apCode` is 11b and `wpPin` is 0.
- R7: While `wpPin` is 1, both `writeAllow` and `silentIgnore` are 0 for every target.
- R8: A config-space target whose `wordAddr[7:5]` is nonzero drives all three outputs to 0. `wordAddr[9:8]` is ignored in config space.
- R9: While `ldAddr` is 1, the outputs reflect the incoming `cfgSel`/`wordAddr` in the same cycle, and that target is captured at the clock edge. While `ldAddr` is 0, the inputs `cfgSel`/`wordAddr` have no effect and the last captured target is used. Reset sets the target to memory address 0.
- R10: `writeAllow` and `silentIgnore` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ldAddr | input | 1 | Load a new target address |
| cfgSel | input | 1 | 1 selects protection/identification space, 0 selects main memory |
| wordAddr | input | 10 | Word address of the access |
| wpPin | input | 1 | Write-protect pin, active high |
| blockCodes | input | 16 | Two-bit permission code per block |
| apCode | input | 2 | Code guarding upper protection bytes and the identification page |
| page0WrEn | input | 8 | Per-page write enables for block 0 |
| stickyBits | input | 9 | Lock bits for protection bytes 0 to 8 (1 = writable) |
| readAllow | output | 1 | Read may proceed |
| writeAllow | output | 1 | Write may be acknowledged and committed |
| silentIgnore | output | 1 | Write is acknowledged but not committed |

## Verification
All three results are combinational. A target presented with `ldAddr` high is judged in that same cycle, and any field change shows up at once. A captured target governs the outputs from the cycle after the edge that loaded it, until the next load. The bench drives inputs shortly after each rising edge, updates its reference target at the rising edge, and compares every output at the falling edge of the same cycle, so each result is checked in the cycle where it is due.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int NUM_BLOCKS    = 8;
  localparam int BLK_BYTES     = 128;
  localparam int PAGE_BYTES    = 16;
  localparam int CODE_W        = 2;
  localparam int CFG_W         = 8;
  localparam int LOCK_BYTES    = 9;
  localparam int FIXED_LO      = 14;

  localparam int MEM_BYTES     = NUM_BLOCKS * BLK_BYTES;
  localparam int ADDR_W        = $clog2(MEM_BYTES);
  localparam int BLK_W         = $clog2(NUM_BLOCKS);
  localparam int PAGES_PER_BLK = BLK_BYTES / PAGE_BYTES;
  localparam int PAGE_W        = $clog2(PAGES_PER_BLK);
  localparam int OFF_W         = $clog2(PAGE_BYTES);
  localparam int CODES_W       = NUM_BLOCKS * CODE_W;

  localparam logic [CODE_W-1:0] CODE_FULL = '1;

  typedef enum logic [2:0] {
    RG_MEM,
    RG_LOCKED,
    RG_GUARDED,
    RG_FIXED,
    RG_NONE
  } region_e;

  typedef struct packed {
    region_e           region;
    logic [BLK_W-1:0]  blk;
    logic [PAGE_W-1:0] page;
    logic [OFF_W-1:0]  cfgByte;
  } sel_t;
endpackage

// File: rtl/bpc_target.sv
module bpc_target
  import bpc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldAddr,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] wordAddr,
  output sel_t              sel
);
  logic              tgtCfg;
  logic [ADDR_W-1:0] tgtAddr;
  logic              effCfg;
  logic [ADDR_W-1:0] effAddr;
  logic [CFG_W-1:0]  cfgAddr;
  logic [OFF_W-1:0]  cfgLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtCfg  <= 1'b0;
      tgtAddr <= '0;
    end else if (ldAddr) begin
      tgtCfg  <= cfgSel;
      tgtAddr <= wordAddr;
    end
  end

  assign effCfg  = ldAddr ? cfgSel   : tgtCfg;
  assign effAddr = ldAddr ? wordAddr : tgtAddr;
  assign cfgAddr = effAddr[CFG_W-1:0];
  assign cfgLow  = cfgAddr[OFF_W-1:0];

  always_comb begin
    sel.blk     = effAddr[ADDR_W-1 -: BLK_W];
    sel.page    = effAddr[OFF_W +: PAGE_W];
    sel.cfgByte = cfgLow;
    if (!effCfg) begin
      sel.region = RG_MEM;
    end else if (|cfgAddr[CFG_W-1:OFF_W+1]) begin
      sel.region = RG_NONE;
    end else if (cfgAddr[OFF_W]) begin
      sel.region = RG_GUARDED;
    end else if (int'(cfgLow) < LOCK_BYTES) begin
      sel.region = RG_LOCKED;
    end else if (int'(cfgLow) >= FIXED_LO) begin
      sel.region = RG_FIXED;
    end else begin
      sel.region = RG_GUARDED;
    end
  end
endmodule

// File: rtl/bpc_rules.sv
module bpc_rules
  import bpc_pkg::*;
(
  input  sel_t                     sel,
  input  logic                     wpPin,
  input  logic [CODES_W-1:0]       blockCodes,
  input  logic [CODE_W-1:0]        apCode,
  input  logic [PAGES_PER_BLK-1:0] page0WrEn,
  input  logic [LOCK_BYTES-1:0]    stickyBits,
  output logic                     readAllow,
  output logic                     writeAllow,
  output logic                     silentIgnore
);
  logic [NUM_BLOCKS-1:0] blkRead;
  logic [NUM_BLOCKS-1:0] blkWrite;
  logic [PAGE_BYTES-1:0] stickyPad;
  logic rdOk, wrOk, ign;

  assign stickyPad = {{(PAGE_BYTES-LOCK_BYTES){1'b0}}, stickyBits};

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic fullCode;
    assign fullCode   = (blockCodes[b*CODE_W +: CODE_W] == CODE_FULL);
    assign blkRead[b] = blockCodes[b*CODE_W + CODE_W - 1];
    if (b == 0) begin : g_paged
      assign blkWrite[b] = fullCode & page0WrEn[sel.page];
    end else begin : g_flat
      assign blkWrite[b] = fullCode;
    end
  end

  always_comb begin
    rdOk = 1'b0;
    wrOk = 1'b0;
    ign  = 1'b0;
    unique case (sel.region)
      RG_MEM: begin
        rdOk = blkRead[sel.blk];
        wrOk = blkWrite[sel.blk];
      end
      RG_LOCKED: begin
        rdOk = 1'b1;
        wrOk = stickyPad[sel.cfgByte];
        ign  = ~stickyPad[sel.cfgByte];
      end
      RG_GUARDED: begin
        rdOk = apCode[CODE_W-1];
        wrOk = (apCode == CODE_FULL);
      end
      RG_FIXED: begin
        rdOk = apCode[CODE_W-1];
        ign  = (apCode == CODE_FULL);
      end
      default: ;
    endcase
  end

  assign readAllow    = rdOk;
  assign writeAllow   = wrOk & ~wpPin;
  assign silentIgnore = ign & ~wpPin;
endmodule

// File: rtl/blk_perm_check.sv
module blk_perm_check
  import bpc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ldAddr,
  input  logic                     cfgSel,
  input  logic [ADDR_W-1:0]        wordAddr,
  input  logic                     wpPin,
  input  logic [CODES_W-1:0]       blockCodes,
  input  logic [CODE_W-1:0]        apCode,
  input  logic [PAGES_PER_BLK-1:0] page0WrEn,
  input  logic [LOCK_BYTES-1:0]    stickyBits,
  output logic                     readAllow,
  output logic                     writeAllow,
  output logic                     silentIgnore
);
  sel_t sel;

  bpc_target u_target (
    .clk      (clk),
    .rstN     (rstN),
    .ldAddr   (ldAddr),
    .cfgSel   (cfgSel),
    .wordAddr (wordAddr),
    .sel      (sel)
  );

  bpc_rules u_rules (
    .sel          (sel),
    .wpPin        (wpPin),
    .blockCodes   (blockCodes),
    .apCode       (apCode),
    .page0WrEn    (page0WrEn),
    .stickyBits   (stickyBits),
    .readAllow    (readAllow),
    .writeAllow   (writeAllow),
    .silentIgnore (silentIgnore)
  );
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker
  import bpc_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     ldAddr,
  input logic                     cfgSel,
  input logic [ADDR_W-1:0]        wordAddr,
  input logic                     wpPin,
  input logic [CODES_W-1:0]       blockCodes,
  input logic [CODE_W-1:0]        apCode,
  input logic [PAGES_PER_BLK-1:0] page0WrEn,
  input logic [LOCK_BYTES-1:0]    stickyBits,
  input logic                     readAllow,
  input logic                     writeAllow,
  input logic                     silentIgnore
);
  // R10
  p_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(writeAllow && silentIgnore));

  // R7
  p_wp_block_r7: assert property (@(posedge clk) disable iff (!rstN)
    wpPin |-> (!writeAllow && !silentIgnore));

  // R1
  p_mem_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ldAddr && !cfgSel) |-> (readAllow == blockCodes[{wordAddr[9:7], 1'b1}]));

  // R3
  p_page0_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ldAddr && !cfgSel && wordAddr[9:7] == 3'd0 && !page0WrEn[wordAddr[6:4]])
      |-> !writeAllow);

  // R4
  p_lock_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ldAddr && cfgSel && wordAddr[7:0] < 8'd9) |-> readAllow);

  // R6
  p_fixed_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ldAddr && cfgSel && wordAddr[7:4] == 4'h0 && wordAddr[3:1] == 3'b111)
      |-> !writeAllow);

  // R8
  p_out_of_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ldAddr && cfgSel && wordAddr[7:5] != 3'd0)
      |-> (!readAllow && !writeAllow && !silentIgnore));

  // R9
  p_hold_target_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!ldAddr && !$past(ldAddr) && $stable(wpPin) && $stable(blockCodes) &&
     $stable(apCode) && $stable(page0WrEn) && $stable(stickyBits))
      |-> ($stable(readAllow) && $stable(writeAllow) && $stable(silentIgnore)));
endmodule

bind blk_perm_check bpc_checker u_chk (.*);

// File: tb/tb_blk_perm_check.sv
module tb_blk_perm_check;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldAddr = 1'b0;
  logic        cfgSel = 1'b0;
  logic [9:0]  wordAddr = '0;
  logic        wpPin = 1'b0;
  logic [15:0] blockCodes = 16'b11_10_01_00_11_11_10_11;
  logic [1:0]  apCode = 2'b11;
  logic [7:0]  page0WrEn = 8'b1010_0101;
  logic [8:0]  stickyBits = 9'b1_0101_0011;
  logic        readAllow, writeAllow, silentIgnore;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference target state
  bit mCfg  = 0;
  int mAddr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_perm_check dut (
    .clk(clk), .rstN(rstN), .ldAddr(ldAddr), .cfgSel(cfgSel),
    .wordAddr(wordAddr), .wpPin(wpPin), .blockCodes(blockCodes),
    .apCode(apCode), .page0WrEn(page0WrEn), .stickyBits(stickyBits),
    .readAllow(readAllow), .writeAllow(writeAllow), .silentIgnore(silentIgnore)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mCfg = 0; mAddr = 0;
    end else if (ldAddr) begin
      mCfg = cfgSel; mAddr = int'(wordAddr);
    end
  end

  function automatic void expect3(input bit cfg, input int addr,
                                  output bit r, output bit w, output bit s,
                                  output string tag);
    int code, blk, pg, a, ap;
    r = 0; w = 0; s = 0;
    ap = int'(apCode);
    if (!cfg) begin
      blk  = addr / 128;
      pg   = (addr / 16) % 8;
      code = (int'(blockCodes) >> (2*blk)) % 4;
      r    = (code >= 2);
      w    = (code == 3) && !wpPin && (blk != 0 || page0WrEn[pg]);
      tag  = (blk == 0) ? "R1/R3" : "R1/R2";
    end else begin
      a = addr % 256;
      if (a >= 32) begin
        tag = "R8";
      end else if (a < 9) begin
        r = 1; w = !wpPin && stickyBits[a]; s = !wpPin && !stickyBits[a];
        tag = "R4";
      end else if (a == 14 || a == 15) begin
        r = (ap >= 2); s = !wpPin && (ap == 3);
        tag = "R6";
      end else begin
        r = (ap >= 2); w = !wpPin && (ap == 3);
        tag = "R5";
      end
    end
    if (wpPin) tag = {tag, "/R7"};
  endfunction

  always @(negedge clk) begin
    bit r, w, s, useCfg;
    int useAddr;
    string tag;
    if (!done) begin
      useCfg  = (rstN && ldAddr) ? cfgSel : mCfg;
      useAddr = (rstN && ldAddr) ? int'(wordAddr) : mAddr;
      if (!rstN) begin useCfg = 0; useAddr = 0; end
      expect3(useCfg, useAddr, r, w, s, tag);
      if (!ldAddr) tag = {tag, "/R9"};
      checks += 4;
      if (readAllow !== r) begin
        fails++;
        $display("FAIL %s readAllow actual=%0b expected=%0b", tag, readAllow, r);
      end
      if (writeAllow !== w) begin
        fails++;
        $display("FAIL %s writeAllow actual=%0b expected=%0b", tag, writeAllow, w);
      end
      if (silentIgnore !== s) begin
        fails++;
        $display("FAIL %s silentIgnore actual=%0b expected=%0b", tag, silentIgnore, s);
      end
      if (writeAllow === 1'b1 && silentIgnore === 1'b1) begin
        fails++;
        $display("FAIL R10 writeAllow&silentIgnore actual=1 expected=0");
      end
    end
  end

  task automatic step(input bit ld, input bit cfg, input int addr);
    @(posedge clk);
    #2;
    ldAddr   = ld;
    cfgSel   = cfg;
    wordAddr = addr[9:0];
  endtask

  initial begin
    // reset state: target is memory address 0 (R9)
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    // R1 R2 R3: every block and page, both pin levels
    for (int wp = 0; wp < 2; wp++) begin
      wpPin = wp[0];
      for (int b = 0; b < 8; b++)
        for (int p = 0; p < 8; p++)
          step(1, 0, b*128 + p*16 + 3);
    end
    wpPin = 0;

    // R4 R5 R6 R8: config space under each guard code, both pin levels
    for (int wp = 0; wp < 2; wp++)
      for (int c = 0; c < 4; c++) begin
        wpPin  = wp[0];
        apCode = c[1:0];
        for (int a = 0; a < 40; a++)
          step(1, 1, a + ((a % 4) << 8));
      end
    wpPin = 0; apCode = 2'b11;
    step(1, 1, 10'h3E5);  // R8 with high bits set

    // R9: held target ignores new addresses; field changes still seen
    step(1, 0, 130);
    for (int k = 0; k < 6; k++) step(0, 1, 40 + k);
    blockCodes = 16'b11_10_01_00_11_11_00_11;
    step(0, 0, 900);
    step(1, 1, 3);
    stickyBits = 9'b0;
    step(0, 0, 5);
    stickyBits = 9'b1_0101_0011;
    step(0, 0, 6);

    // mixed traffic
    for (int k = 0; k < 1500; k++) begin
      blockCodes = 16'($urandom);
      apCode     = 2'($urandom);
      page0WrEn  = 8'($urandom);
      stickyBits = 9'($urandom);
      wpPin      = ($urandom % 4) == 0;
      step(($urandom % 3) != 0, $urandom % 2, int'($urandom % 1024));
    end

    @(posedge clk);
    @(negedge clk);
    #1 done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule